// File: doc/BRIEF.md
# Free-Running Timer With Latched Read

This block is a 12-bit up-counter that advances once per 1 µs tick enable and wraps from 4095 back to 0, so it spans roughly 4 ms of elapsed time. Software reads the count over an 8-bit data path in two steps. One strobe returns bits 7 to 0. A second strobe returns bits 11 to 8 in the low nibble, with zeros in the upper nibble.

When the low byte is read, the upper four bits of the same count value are copied into a holding register on that same clock edge. The upper read returns this held copy and not the live counter. A split read therefore gives one consistent 12-bit value, however long software waits between the two strobes.

The block also produces two periodic one-cycle interrupt pulses. The fast one fires every 128 ticks and the slow one every 1024 ticks. They are meant to drive an interrupt controller outside this block.

Top module: `ftmr_top`

## Requirements
- R1: The counter starts at 0 after reset, increases by exactly one at each clock edge where `tick_en` is 1, keeps its value when `tick_en` is 0, and wraps from 4095 to 0.
- R2: When `rd_lo` is 1 at a clock edge, `rd_data` shows counter bits 7..0 from the cycle after that edge. The value is the counter as it stood before the edge, so a tick in the same cycle is not included. On that same edge, counter bits 11..8 of the same value are copied into the holding register.
- R3: When `rd_hi` is 1 and `rd_lo` is 0 at a clock edge, `rd_data` shows {4'b0000, holding register} from the next cycle. Bits 7..4 read as zero. The held value is the one captured at the last low read, however many ticks have passed since then.
- R4: When `rd_lo` and `rd_hi` are both 1 in the same cycle, the low read takes priority and the high read is ignored.
- R5: When neither strobe is 1, `rd_data` keeps its previous value.
- R6: `irq_fast` is 1 for exactly the one cycle after the edge at which a tick moves counter bits 6..0 from 127 to 0. It is 0 at all other times.
- R7: `irq_slow` is 1 for exactly the one cycle after the edge at which a tick moves counter bits 9..0 from 1023 to 0. It is 0 at all other times.
- R8: While `rst_n` is 0, the counter, the holding register and `rd_data` go to 0, and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 1 µs advance enable |
| rd_lo | input | 1 | Read strobe for count bits 7..0; also loads the holding register |
| rd_hi | input | 1 | Read strobe for the held bits 11..8 |
| rd_data | output | 8 | Registered read data |
| irq_fast | output | 1 | Pulse every 128 ticks |
| irq_slow | output | 1 | Pulse every 1024 ticks |

## Verification
A counter that skips or repeats a tick does not stay hidden. It shows at the very next low read as a byte that differs from the number of ticks issued, and it moves the next interrupt pulse off the 128-tick grid. A holding register that follows the live count, or that is loaded at the wrong edge, only shows on an upper read. The bench therefore places upper reads after long runs of ticks, where the stale copy and the live bits differ. Priority, hold and reset faults each appear in `rd_data` on the first cycle after the offending strobe.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam int unsigned CNT_W     = 12;
  localparam int unsigned RD_W      = 8;
  localparam int unsigned FAST_LOG2 = 7;
  localparam int unsigned SLOW_LOG2 = 10;

  // next value of a free-running count, wrapping at the width
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  // true when the low nbits of c are all ones (next tick wraps them to zero)
  function automatic logic low_all_ones(input logic [CNT_W-1:0] c,
                                        input int unsigned nbits);
    logic [CNT_W-1:0] m;
    m = CNT_W'((64'd1 << nbits) - 64'd1);
    return (c & m) == m;
  endfunction
endpackage

// File: rtl/ftmr_counter.sv
module ftmr_counter
  import ftmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end
endmodule

// File: rtl/ftmr_irq_gen.sv
module ftmr_irq_gen
  import ftmr_pkg::*;
#(
  parameter int unsigned LOG2_PERIOD = FAST_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] count,
  output logic             irq
);
  logic wrap_now;
  assign wrap_now = tick_en && low_all_ones(count, LOG2_PERIOD);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wrap_now;
  end
endmodule

// File: rtl/ftmr_read_port.sv
module ftmr_read_port
  import ftmr_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned DW = RD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic [W-1:0]  count,
  output logic [W-DW-1:0] snap,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned HW = W - DW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap    <= '0;
      rd_data <= '0;
    end else if (rd_lo) begin
      snap    <= count[W-1:DW];
      rd_data <= count[DW-1:0];
    end else if (rd_hi) begin
      rd_data <= DW'(snap);
    end
  end

  initial begin
    if (HW > DW) $display("ftmr_read_port: high part wider than data path");
  end
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top
  import ftmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            rd_lo,
  input  logic            rd_hi,
  output logic [RD_W-1:0] rd_data,
  output logic            irq_fast,
  output logic            irq_slow
);
  localparam int unsigned HW = CNT_W - RD_W;
  localparam int unsigned NIRQ = 2;
  localparam int unsigned LOG2S [NIRQ] = '{FAST_LOG2, SLOW_LOG2};

  logic [CNT_W-1:0] count;
  logic [HW-1:0]    snap;
  logic [NIRQ-1:0]  irq_vec;

  ftmr_counter #(.W(CNT_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count)
  );

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    ftmr_irq_gen #(.LOG2_PERIOD(LOG2S[g])) i_irq (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count), .irq(irq_vec[g])
    );
  end

  ftmr_read_port #(.W(CNT_W), .DW(RD_W)) i_rd (
    .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .count(count), .snap(snap), .rd_data(rd_data)
  );

  assign irq_fast = irq_vec[0];
  assign irq_slow = irq_vec[1];
endmodule

// File: rtl/ftmr_chk.sv
module ftmr_chk
  import ftmr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_en,
  input logic                  rd_lo,
  input logic                  rd_hi,
  input logic [RD_W-1:0]       rd_data,
  input logic                  irq_fast,
  input logic                  irq_slow,
  input logic [CNT_W-1:0]      count,
  input logic [CNT_W-RD_W-1:0] snap
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> count == CNT_W'($past(count) + 1'b1));
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));
  // R2
  lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (rd_data == $past(count[RD_W-1:0])) && (snap == $past(count[CNT_W-1:RD_W])));
  // R3
  hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) |=> rd_data == RD_W'($past(snap)));
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |=> $stable(rd_data));
  // R6
  fast_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> (count[FAST_LOG2-1:0] == '0) && $past(tick_en));
  // R7
  slow_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |-> (count[SLOW_LOG2-1:0] == '0) && $past(tick_en) && irq_fast);
endmodule

bind ftmr_top ftmr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .rd_data(rd_data), .irq_fast(irq_fast), .irq_slow(irq_slow),
  .count(count), .snap(snap)
);

// File: tb/test_ftmr_top.sv
module test_ftmr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic irq_fast, irq_slow;

  always #10 clk = ~clk;

  ftmr_top i_ftmr_top (.*);

  int n_chk = 0, n_bad = 0, n_fast = 0, n_slow = 0;
  bit done = 0;
  logic [11:0] m_cnt = '0;
  logic [3:0]  m_snap = '0;
  logic [7:0]  m_rd = '0;

  typedef struct packed {
    logic [12:0] reps;
    logic        hi;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{13'd0,    1'b0, 8'h00}, '{13'd5,    1'b0, 8'h05},
    '{13'd0,    1'b1, 8'h00}, '{13'd300,  1'b0, 8'h31},
    '{13'd0,    1'b1, 8'h01}, '{13'd1000, 1'b0, 8'h19},
    '{13'd2000, 1'b1, 8'h05}, '{13'd0,    1'b0, 8'hE9},
    '{13'd0,    1'b1, 8'h0C}, '{13'd800,  1'b0, 8'h09},
    '{13'd0,    1'b1, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // caller sits at a negedge; one clock cycle with the given inputs
  task automatic step(input logic t, input logic l, input logic h);
    logic [11:0] pre;
    logic ef, es;
    tick_en = t; rd_lo = l; rd_hi = h;
    @(posedge clk);
    pre = m_cnt;
    ef = t && (pre[6:0] == 7'h7F);
    es = t && (pre[9:0] == 10'h3FF);
    if (l) begin m_rd = pre[7:0]; m_snap = pre[11:8]; end
    else if (h) m_rd = {4'b0000, m_snap};
    if (t) m_cnt = m_cnt + 12'd1;
    @(negedge clk);
    if (irq_fast) n_fast++;
    if (irq_slow) n_slow++;
    chk("R6 irq_fast", 32'(irq_fast), 32'(ef));
    chk("R7 irq_slow", 32'(irq_slow), 32'(es));
    chk("R2/R3/R5 rd_data model", 32'(rd_data), 32'(m_rd));
    tick_en = 0; rd_lo = 0; rd_hi = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 rd_data in reset", 32'(rd_data), 0);
    chk("R8 irq_fast in reset", 32'(irq_fast), 0);
    chk("R8 irq_slow in reset", 32'(irq_slow), 0);
    rst_n = 1'b1;

    // table walk: R1 counting and wrap, R2 low read, R3 stale high read
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i].reps); k++) step(1'b1, 1'b0, 1'b0);
      step(1'b0, !VEC[i].hi, VEC[i].hi);
      chk(VEC[i].hi ? "R3 table high read" : "R1/R2 table low read",
          32'(rd_data), 32'(VEC[i].exp));
    end
    // 4105 ticks from zero cross 32 fast and 4 slow boundaries
    chk("R6 fast pulse total", n_fast, 32);
    chk("R7 slow pulse total", n_slow, 4);

    // R5 hold with no strobes while ticking
    held = rd_data;
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R5 hold", 32'(rd_data), 32'(held));

    // now count = 10; run to 309 = 0x135
    for (int k = 0; k < 299; k++) step(1'b1, 1'b0, 1'b0);
    // R4 both strobes: low wins
    step(1'b0, 1'b1, 1'b1);
    chk("R4 both strobes low wins", 32'(rd_data), 32'h35);
    step(1'b0, 1'b0, 1'b1);
    chk("R4 snapshot taken by combined strobe", 32'(rd_data), 32'h01);
    // R2 tick in same cycle as low read returns pre-tick value
    step(1'b1, 1'b1, 1'b0);
    chk("R2 low read with tick", 32'(rd_data), 32'h35);
    step(1'b0, 1'b1, 1'b0);
    chk("R1 tick counted after read", 32'(rd_data), 32'h36);

    // R8 reset mid-run
    for (int k = 0; k < 700; k++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 rd_data after reset", 32'(rd_data), 0);
    rst_n = 1'b1;
    m_cnt = '0; m_snap = '0; m_rd = '0;
    step(1'b0, 1'b0, 1'b1);
    chk("R8 holding register cleared", 32'(rd_data), 0);
    step(1'b0, 1'b1, 1'b0);
    chk("R8 counter cleared", 32'(rd_data), 0);

    // R6 first fast pulse exactly on the 128th tick after reset
    for (int k = 0; k < 127; k++) step(1'b1, 1'b0, 1'b0);
    chk("R6 no pulse before 128th tick", 32'(irq_fast), 0);
    step(1'b1, 1'b0, 1'b0);
    chk("R6 pulse on 128th tick", 32'(irq_fast), 1);
    step(1'b0, 1'b0, 1'b0);
    chk("R6 pulse lasts one cycle", 32'(irq_fast), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule